// File: doc/BRIEF.md
# Four-Group Precessing Recirculating Memory

This block models a serial recirculating store and the controller that makes its contents precess. The store holds `GROUPS` groups of `PAIRS` bit-pairs; each pair is an S bit followed by a V bit. It is read out as a serial stream. During each memory cycle a marker slot comes first. Then every information bit emerges once, in group order, with pairs in order and S before V inside each pair. Each bit is written back two slots behind the read position. The result is that the pairs of every group rotate by one position per memory cycle, each group on its own.

Two holding flip-flops take the first pair of each group. The held S bit is written back into the slot where the next group's first S emerges, or into the first of two tail slots after the last group. A released V bit does not go straight back. It enters a V delay chain with one stage per group, which shifts at every group boundary. The chain returns that bit to the same group one full memory cycle later. As a result, the S bits of a group form a ring of `PAIRS` and the V bits form a ring of `PAIRS+1`.

Between memory cycles the controller idles for a programmable number of clocks and waits for `run_i`. During that idle time a port addressed by group, pair and S/V selector can preload the store or read it back.

Top module: `precess_mem`

## Requirements
- R1: After reset the controller is idle (`busy_o`=0), `cyc_o`, `mach_o`, `hold_s_o`, `hold_v_o`, `vchain_o` and `bitper_o` are all 0, and every stored bit reads 0.
- R2: While idle, a write with `wr_en_i`=1 stores `wr_data_i` at line position grp*2*PAIRS + 2*pair + sv (sv=0 selects S, sv=1 selects V). `rd_data_o` combinationally returns the bit at the position addressed by `grp_i`/`pair_i`/`sv_i`.
- R3: One memory cycle moves the S bit of pair p+1 to pair p within each group, and moves pair 0's S bit to pair PAIRS-1 of the same group.
- R4: One memory cycle moves the V bit of pair p+1 to pair p. Pair PAIRS-1 receives the V bit that its group released one memory cycle earlier (0 for the first cycle after reset), and the V chain keeps the group's current pair-0 V bit. V contents therefore repeat every PAIRS+1 memory cycles.
- R5: The S layout returns to its preloaded form after PAIRS memory cycles. `mach_o` is high together with `cyc_o` exactly at the end of every PAIRS-th memory cycle.
- R6: A memory cycle keeps `busy_o` high for 2*GROUPS*PAIRS+3 clocks: one marker clock, one clock per stored bit, and two tail clocks. `cyc_o` is high in the last tail clock, and `busy_o` is low in the clock after it.
- R7: After a memory cycle the controller stays idle for at least `gap_len_i`+1 clocks. It starts the next cycle only while `run_i` is high, so with `run_i` held high cycles repeat every 2*GROUPS*PAIRS+4+`gap_len_i` clocks.
- R8: `bitper_o` reads 0 in the marker clock, reads k/(2*PAIRS) in the k-th bit slot (k from 0), and reads GROUPS-1 in both tail clocks.
- R9: While idle after memory cycle n, `hold_s_o` and `hold_v_o` hold the S and V bits that were pair 0 of the last group at the start of that cycle. `vchain_o[GROUPS-1-g]` holds the V bit released by group g in that cycle. All three stay stable throughout the idle period.
- R10: Preload writes presented while `busy_o` is high are ignored and leave the stored contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Permit to start the next memory cycle |
| gap_len_i | input | GAPW | Minimum idle clocks between cycles, minus one |
| wr_en_i | input | 1 | Preload write strobe (idle only) |
| grp_i | input | clog2(GROUPS) | Preload/read group |
| pair_i | input | clog2(PAIRS) | Preload/read pair index |
| sv_i | input | 1 | 0 selects the S bit, 1 selects the V bit |
| wr_data_i | input | 1 | Preload data |
| rd_data_o | output | 1 | Read-back of the addressed bit |
| hold_s_o | output | 1 | Held S flip-flop |
| hold_v_o | output | 1 | Held V flip-flop |
| vchain_o | output | GROUPS | V delay chain, bit 0 newest |
| bitper_o | output | clog2(GROUPS) | Bit-period (group) index of the current slot |
| busy_o | output | 1 | Memory cycle in progress |
| cyc_o | output | 1 | Last clock of a memory cycle |
| mach_o | output | 1 | Last clock of a machine cycle |

## Verification
The hardest behaviour to reach is the V ring of length PAIRS+1. It only shows after more than PAIRS cycles, and only if each group carries a pattern with no rotational symmetry. Otherwise a wrong hand-off at a group boundary or a missing chain stage could look like a correct rotation. The stimulus preloads a distinct irregular pattern into each group of a small configuration, runs twice the V period of memory cycles, and compares every position, the holding flops and the chain against arithmetic rotation after each cycle. A preload write is also injected in the middle of one cycle to show that it has no effect.

// File: rtl/precess_pkg.sv
package precess_pkg;

    // Controller phases of one memory cycle
    typedef enum logic [1:0] {
        ST_GAP   = 2'd0,  // idle between cycles, preload allowed
        ST_MARK  = 2'd1,  // marker slot
        ST_SHIFT = 2'd2,  // information bits emerging
        ST_FLUSH = 2'd3   // two tail slots returning held bits
    } pstate_t;

    // Source of the bit written back into the line in a slot
    typedef enum logic [1:0] {
        INS_NONE   = 2'd0,
        INS_PASS   = 2'd1,
        INS_HELD_S = 2'd2,
        INS_HELD_V = 2'd3
    } ins_t;

endpackage

// File: rtl/precess_seq.sv
module precess_seq
    import precess_pkg::*;
#(
    parameter  int GROUPS = 4,
    parameter  int PAIRS  = 60,
    parameter  int GAPW   = 8,
    localparam int GW     = 2 * PAIRS,
    localparam int IW     = $clog2(GW),
    localparam int GRW    = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    localparam int CW     = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic [GAPW-1:0] gap_len_i,
    output logic [GRW-1:0]  grp_o,
    output logic [IW-1:0]   idx_o,
    output ins_t            ins_o,
    output logic            cap_s_o,
    output logic            cap_v_o,
    output logic            push_o,
    output logic            start_o,
    output logic            busy_o,
    output logic            cyc_o,
    output logic            mach_o,
    output logic [GRW-1:0]  bitper_o
);

    pstate_t         state_q;
    logic [GRW-1:0]  grp_q;
    logic [IW-1:0]   idx_q;
    logic [GAPW-1:0] gcnt_q;
    logic [CW-1:0]   ccnt_q;

    logic last_idx, last_grp;
    assign last_idx = (idx_q == IW'(GW - 1));
    assign last_grp = (grp_q == GRW'(GROUPS - 1));

    // State register and slot counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_GAP;
            grp_q   <= '0;
            idx_q   <= '0;
            gcnt_q  <= '0;
            ccnt_q  <= '0;
        end else begin
            unique case (state_q)
                ST_GAP: begin
                    if (gcnt_q >= gap_len_i && run_i) begin
                        state_q <= ST_MARK;
                    end else if (gcnt_q != '1) begin
                        gcnt_q <= gcnt_q + 1'b1;
                    end
                end
                ST_MARK: begin
                    state_q <= ST_SHIFT;
                    grp_q   <= '0;
                    idx_q   <= '0;
                end
                ST_SHIFT: begin
                    if (last_idx) begin
                        idx_q <= '0;
                        if (last_grp) begin
                            state_q <= ST_FLUSH;
                        end else begin
                            grp_q <= grp_q + 1'b1;
                        end
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_FLUSH: begin
                    if (idx_q == IW'(1)) begin
                        state_q <= ST_GAP;
                        gcnt_q  <= '0;
                        idx_q   <= '0;
                        grp_q   <= '0;
                        ccnt_q  <= (ccnt_q == CW'(PAIRS - 1)) ? '0 : ccnt_q + 1'b1;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // Slot actions decoded from the state
    always_comb begin
        ins_o    = INS_NONE;
        cap_s_o  = 1'b0;
        cap_v_o  = 1'b0;
        push_o   = 1'b0;
        start_o  = 1'b0;
        cyc_o    = 1'b0;
        mach_o   = 1'b0;
        bitper_o = '0;
        busy_o   = (state_q != ST_GAP);
        unique case (state_q)
            ST_GAP:  ;
            ST_MARK: start_o = 1'b1;
            ST_SHIFT: begin
                bitper_o = grp_q;
                if (idx_q == IW'(0)) begin
                    cap_s_o = 1'b1;
                    ins_o   = (grp_q == '0) ? INS_NONE : INS_HELD_S;
                end else if (idx_q == IW'(1)) begin
                    cap_v_o = 1'b1;
                    push_o  = (grp_q != '0);
                    ins_o   = (grp_q == '0) ? INS_NONE : INS_HELD_V;
                end else begin
                    ins_o = INS_PASS;
                end
            end
            ST_FLUSH: begin
                bitper_o = GRW'(GROUPS - 1);
                if (idx_q == IW'(0)) begin
                    ins_o = INS_HELD_S;
                end else begin
                    ins_o  = INS_HELD_V;
                    push_o = 1'b1;
                    cyc_o  = 1'b1;
                    mach_o = (ccnt_q == CW'(PAIRS - 1));
                end
            end
        endcase
    end

    assign grp_o = grp_q;
    assign idx_o = idx_q;

endmodule

// File: rtl/precess_line.sv
module precess_line
    import precess_pkg::*;
#(
    parameter  int GROUPS = 4,
    parameter  int PAIRS  = 60,
    localparam int GW     = 2 * PAIRS,
    localparam int LEN    = GROUPS * GW,
    localparam int AW     = $clog2(LEN),
    localparam int IW     = $clog2(GW),
    localparam int GRW    = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    localparam int PW     = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           accept_i,
    input  logic           wr_en_i,
    input  logic [GRW-1:0] grp_i,
    input  logic [PW-1:0]  pair_i,
    input  logic           sv_i,
    input  logic           wr_data_i,
    output logic           rd_data_o,
    input  logic           start_i,
    input  logic [GRW-1:0] rgrp_i,
    input  logic [IW-1:0]  ridx_i,
    input  ins_t           ins_i,
    input  logic           held_s_i,
    input  logic           held_v_i,
    output logic           emerge_o
);

    logic [LEN-1:0] mem_q;
    logic [AW-1:0]  wp_q;
    int unsigned    hpos, ppos;
    logic           ins_bit;

    always_comb begin
        hpos     = int'(rgrp_i) * GW + int'(ridx_i);
        ppos     = int'(grp_i) * GW + 2 * int'(pair_i) + int'(sv_i);
        emerge_o = (hpos < LEN) ? mem_q[hpos[AW-1:0]] : 1'b0;
        rd_data_o = (ppos < LEN) ? mem_q[ppos[AW-1:0]] : 1'b0;
        unique case (ins_i)
            INS_NONE:   ins_bit = 1'b0;
            INS_PASS:   ins_bit = emerge_o;
            INS_HELD_S: ins_bit = held_s_i;
            INS_HELD_V: ins_bit = held_v_i;
        endcase
    end

    // Write-back trails the read position by two slots
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
            wp_q  <= '0;
        end else begin
            if (start_i) begin
                wp_q <= '0;
            end else if (ins_i != INS_NONE) begin
                mem_q[wp_q] <= ins_bit;
                wp_q        <= wp_q + 1'b1;
            end
            if (accept_i && wr_en_i && ppos < LEN) begin
                mem_q[ppos[AW-1:0]] <= wr_data_i;
            end
        end
    end

endmodule

// File: rtl/precess_hold.sv
module precess_hold #(
    parameter int GROUPS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_s_i,
    input  logic              cap_v_i,
    input  logic              push_i,
    input  logic              bit_i,
    output logic              s_o,
    output logic              v_o,
    output logic [GROUPS-1:0] chain_o,
    output logic              chain_out_o
);

    logic              s_q, v_q;
    logic [GROUPS-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= 1'b0;
            v_q     <= 1'b0;
            chain_q <= '0;
        end else begin
            if (cap_s_i) s_q <= bit_i;
            if (cap_v_i) v_q <= bit_i;
            if (push_i) begin
                chain_q[0] <= v_q;
                for (int k = 1; k < GROUPS; k++) begin
                    chain_q[k] <= chain_q[k-1];
                end
            end
        end
    end

    assign s_o         = s_q;
    assign v_o         = v_q;
    assign chain_o     = chain_q;
    assign chain_out_o = chain_q[GROUPS-1];

endmodule

// File: rtl/precess_mem.sv
module precess_mem
    import precess_pkg::*;
#(
    parameter  int GROUPS = 4,
    parameter  int PAIRS  = 60,
    parameter  int GAPW   = 8,
    localparam int GW     = 2 * PAIRS,
    localparam int IW     = $clog2(GW),
    localparam int GRW    = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    localparam int PW     = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [GAPW-1:0]   gap_len_i,
    input  logic              wr_en_i,
    input  logic [GRW-1:0]    grp_i,
    input  logic [PW-1:0]     pair_i,
    input  logic              sv_i,
    input  logic              wr_data_i,
    output logic              rd_data_o,
    output logic              hold_s_o,
    output logic              hold_v_o,
    output logic [GROUPS-1:0] vchain_o,
    output logic [GRW-1:0]    bitper_o,
    output logic              busy_o,
    output logic              cyc_o,
    output logic              mach_o
);

    logic [GRW-1:0] grp_w;
    logic [IW-1:0]  idx_w;
    ins_t           ins_w;
    logic           cap_s_w, cap_v_w, push_w, start_w;
    logic           emerge_w, chain_out_w;

    precess_seq #(.GROUPS(GROUPS), .PAIRS(PAIRS), .GAPW(GAPW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_i),
        .gap_len_i (gap_len_i),
        .grp_o     (grp_w),
        .idx_o     (idx_w),
        .ins_o     (ins_w),
        .cap_s_o   (cap_s_w),
        .cap_v_o   (cap_v_w),
        .push_o    (push_w),
        .start_o   (start_w),
        .busy_o    (busy_o),
        .cyc_o     (cyc_o),
        .mach_o    (mach_o),
        .bitper_o  (bitper_o)
    );

    precess_line #(.GROUPS(GROUPS), .PAIRS(PAIRS)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (!busy_o),
        .wr_en_i   (wr_en_i),
        .grp_i     (grp_i),
        .pair_i    (pair_i),
        .sv_i      (sv_i),
        .wr_data_i (wr_data_i),
        .rd_data_o (rd_data_o),
        .start_i   (start_w),
        .rgrp_i    (grp_w),
        .ridx_i    (idx_w),
        .ins_i     (ins_w),
        .held_s_i  (hold_s_o),
        .held_v_i  (chain_out_w),
        .emerge_o  (emerge_w)
    );

    precess_hold #(.GROUPS(GROUPS)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_s_i     (cap_s_w),
        .cap_v_i     (cap_v_w),
        .push_i      (push_w),
        .bit_i       (emerge_w),
        .s_o         (hold_s_o),
        .v_o         (hold_v_o),
        .chain_o     (vchain_o),
        .chain_out_o (chain_out_w)
    );

endmodule

// File: rtl/precess_mem_chk.sv
module precess_mem_chk #(
    parameter  int GROUPS = 4,
    localparam int GRW    = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              cyc_o,
    input logic              mach_o,
    input logic [GRW-1:0]    bitper_o,
    input logic              hold_s_o,
    input logic              hold_v_o,
    input logic [GROUPS-1:0] vchain_o
);

    assert_gap_follows_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_o |=> !busy_o);

    assert_cycle_strobe_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_o |-> busy_o);

    assert_mach_with_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mach_o |-> cyc_o);

    assert_marker_period_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (bitper_o == '0));

    assert_held_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $past(!busy_o)) |->
            ($stable(hold_s_o) && $stable(hold_v_o) && $stable(vchain_o)));

endmodule

bind precess_mem precess_mem_chk #(.GROUPS(GROUPS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy_o   (busy_o),
    .cyc_o    (cyc_o),
    .mach_o   (mach_o),
    .bitper_o (bitper_o),
    .hold_s_o (hold_s_o),
    .hold_v_o (hold_v_o),
    .vchain_o (vchain_o)
);

// File: tb/precess_mem_bench.sv
`timescale 1ns/1ps
module precess_mem_bench;

    localparam int G  = 4;
    localparam int P  = 5;
    localparam int BUSY_CLKS = 2 * G * P + 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_i = 1'b0;
    logic [7:0] gap_len_i = 8'd2;
    logic       wr_en_i = 1'b0;
    logic [1:0] grp_i = '0;
    logic [2:0] pair_i = '0;
    logic       sv_i = 1'b0;
    logic       wr_data_i = 1'b0;
    logic       rd_data_o, hold_s_o, hold_v_o, busy_o, cyc_o, mach_o;
    logic [G-1:0] vchain_o;
    logic [1:0] bitper_o;

    int checks = 0;
    int fails  = 0;
    int n      = 0;
    bit done   = 1'b0;
    bit os [G][P];
    bit ov [G][P];

    always #10 clk = ~clk;

    precess_mem #(.GROUPS(G), .PAIRS(P), .GAPW(8)) u_precess_mem (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .gap_len_i(gap_len_i),
        .wr_en_i(wr_en_i), .grp_i(grp_i), .pair_i(pair_i), .sv_i(sv_i),
        .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .hold_s_o(hold_s_o),
        .hold_v_o(hold_v_o), .vchain_o(vchain_o), .bitper_o(bitper_o),
        .busy_o(busy_o), .cyc_o(cyc_o), .mach_o(mach_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int ringv(input int g, input int k);
        return (k == P) ? 0 : int'(ov[g][k]);
    endfunction

    task automatic rd(input int g, input int p, input int sv, output int b);
        grp_i  = 2'(g);
        pair_i = 3'(p);
        sv_i   = sv[0];
        #1;
        b = int'(rd_data_o);
    endtask

    task automatic end_of_cycle();
        n++;
        check("R5", "machine strobe", int'(mach_o), int'((n % P) == 0));
    endtask

    // Compare every stored bit and the holding state against rotation arithmetic
    task automatic verify();
        int b;
        int bad_s = 0;
        int bad_v = 0;
        for (int g = 0; g < G; g++) begin
            for (int p = 0; p < P; p++) begin
                rd(g, p, 0, b);
                check("R3", $sformatf("S g%0d p%0d n%0d", g, p, n), b, int'(os[g][(p + n) % P]));
                if (b != int'(os[g][(p + n) % P])) bad_s++;
                rd(g, p, 1, b);
                check("R4", $sformatf("V g%0d p%0d n%0d", g, p, n), b, ringv(g, (p + n) % (P + 1)));
                if (b != ringv(g, (p + n) % (P + 1))) bad_v++;
            end
        end
        if (n == P)     check("R5", "S layout restored", bad_s, 0);
        if (n == P + 1) check("R4", "V layout restored", bad_v, 0);
        if (n >= 1) begin
            check("R9", "held S", int'(hold_s_o), int'(os[G-1][(n - 1) % P]));
            check("R9", "held V", int'(hold_v_o), ringv(G - 1, (n - 1) % (P + 1)));
            for (int g = 0; g < G; g++) begin
                check("R9", $sformatf("chain group %0d", g), int'(vchain_o[G-1-g]),
                      ringv(g, (n - 1) % (P + 1)));
            end
        end
    endtask

    task automatic run_cycle(input bit poke);
        int j = 0;
        int bad = 0;
        int expb;
        @(negedge clk);
        run_i = 1'b1;
        forever begin
            @(negedge clk);
            if (busy_o) begin
                if (j == 0) expb = 0;
                else if (j <= 2 * G * P) expb = (j - 1) / (2 * P);
                else expb = G - 1;
                if (int'(bitper_o) != expb) bad++;
                if (poke && j == 7) begin
                    wr_en_i = 1'b1; grp_i = 2'd1; pair_i = 3'd2; sv_i = 1'b1;
                    wr_data_i = ~ov[1][(2 + n) % P];
                end
                if (poke && j == 20) begin
                    grp_i = 2'd0; pair_i = 3'd0; sv_i = 1'b0; wr_data_i = ~os[0][n % P];
                end
                if (poke && j == 30) wr_en_i = 1'b0;
                if (cyc_o) begin
                    run_i = 1'b0;
                    check("R6", "busy clocks per cycle", j + 1, BUSY_CLKS);
                    check("R8", "bit-period mismatches", bad, 0);
                    end_of_cycle();
                    break;
                end
                j++;
            end
        end
        @(negedge clk);
        check("R6", "idle after cycle strobe", int'(busy_o), 0);
    endtask

    task automatic measure_gap(input int gl);
        int cnt = 0;
        @(negedge clk);
        gap_len_i = 8'(gl);
        run_i = 1'b1;
        do @(negedge clk); while (!cyc_o);
        end_of_cycle();
        forever begin
            @(negedge clk);
            cnt++;
            if (cyc_o) break;
        end
        run_i = 1'b0;
        end_of_cycle();
        check("R7", $sformatf("cycle period gap %0d", gl), cnt, BUSY_CLKS + gl + 1);
        @(negedge clk);
    endtask

    initial begin
        int b;
        int nz = 0;
        for (int g = 0; g < G; g++) begin
            for (int p = 0; p < P; p++) begin
                os[g][p] = (((g * 7 + p * p + p) % 3) == 0);
                ov[g][p] = (((g * 3 + 2 * p * p + 1) % 5) < 2);
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "busy", int'(busy_o), 0);
        check("R1", "cycle strobe", int'(cyc_o), 0);
        check("R1", "machine strobe", int'(mach_o), 0);
        check("R1", "held S", int'(hold_s_o), 0);
        check("R1", "held V", int'(hold_v_o), 0);
        check("R1", "chain", int'(vchain_o), 0);
        check("R1", "bit period", int'(bitper_o), 0);
        for (int g = 0; g < G; g++)
            for (int p = 0; p < P; p++)
                for (int sv = 0; sv < 2; sv++) begin
                    rd(g, p, sv, b);
                    nz += b;
                end
        check("R1", "nonzero stored bits", nz, 0);

        // R2 preload through the idle-time port
        for (int g = 0; g < G; g++)
            for (int p = 0; p < P; p++)
                for (int sv = 0; sv < 2; sv++) begin
                    @(negedge clk);
                    wr_en_i = 1'b1;
                    grp_i = 2'(g); pair_i = 3'(p); sv_i = sv[0];
                    wr_data_i = (sv == 0) ? os[g][p] : ov[g][p];
                end
        @(negedge clk);
        wr_en_i = 1'b0;
        rd(2, 3, 0, b);
        check("R2", "read-back S g2 p3", b, int'(os[2][3]));
        rd(3, 4, 1, b);
        check("R2", "read-back V g3 p4", b, int'(ov[3][4]));
        verify();

        // R7 no start while run_i is low
        nz = 0;
        repeat (20) begin
            @(negedge clk);
            nz += int'(busy_o);
        end
        check("R7", "busy clocks with run low", nz, 0);

        for (int c = 1; c <= 2 * (P + 1); c++) begin
            run_cycle(c == 3);  // cycle 3 carries ignored writes for R10
            verify();
            if (c == 3) begin
                rd(1, 2, 1, b);
                check("R10", "write during busy ignored", b, ringv(1, (2 + n) % (P + 1)));
            end
        end

        measure_gap(0);
        verify();
        measure_gap(6);
        verify();

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule